// File: doc/BRIEF.md
# Successive-Approximation Converter Readout Controller

This block is the host side of a link to an 18-bit successive-approximation converter. The converter runs in a four-wire chip-select mode that reports its own end of conversion. When the host asks for a sample, the controller raises the convert line while the select line is already high, so the converter enters chip-select mode. After a short, programmable hold it lowers the select line. It then watches the shared, pulled-up data line. Once the converter pulls that line low, the conversion is complete.

The controller then toggles the serial clock and collects the data bits, most significant bit first. Each bit is read at the end of the low phase that follows a falling clock edge. An optional extra falling edge releases the data line. Finally the controller drops the convert line and raises the select line, which releases the data line if the extra edge was not used. It presents the word with a one-cycle strobe. If the data line never falls within a maximum window, the controller ends the frame and raises a sticky error flag. Counts for the select hold, the minimum and maximum conversion windows and the serial clock half-period are parameters in system clock cycles.

Top module: `sar_readout`

## Requirements
- R1: After synchronous reset, conv_o=0, sel_o=1, sclk_o=0, valid_o=0 and err_o=0.
- R2: A start_i seen in idle raises conv_o on the next edge while sel_o is high. sel_o stays high for exactly SEL_HOLD cycles of conv_o high, then goes low. SEL_HOLD must not exceed T_MIN.
- R3: conv_o stays high without a break from the start until the frame ends. It falls only in the cycle where valid_o or err_o is raised.
- R4: A low level on sdo_i counts as end of conversion only once T_MIN or more cycles have passed since conv_o rose. A low level seen earlier is ignored.
- R5: sel_o is low whenever sclk_o is high, and sclk_o is high only while conv_o is high.
- R6: Each serial clock period is HALF_CYC cycles low followed by HALF_CYC cycles high. The clock starts low. After the n-th falling edge (n=1..NBITS), the bit is sampled at the end of the low phase. The first bit is the MSB (bit 17) and it lands in data_o[17].
- R7: A frame has exactly NBITS+EXTRA_EDGE rising edges of sclk_o. With EXTRA_EDGE=1 the frame ends on the 19th falling edge.
- R8: On completion conv_o falls, sel_o rises and valid_o is high for exactly one cycle. data_o holds the captured word until the next successful frame.
- R9: If sdo_i has not been seen low by the time the count reaches T_MAX, the frame ends with conv_o low and no serial clock, and valid_o is not asserted. err_o is set and stays set until the next start. A low seen at count T_MAX itself is still accepted.
- R10: start_i is ignored while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion and readout |
| sdo_i | input | 1 | Shared data line from converter, high when released |
| conv_o | output | 1 | Convert line to the converter |
| sel_o | output | 1 | Select line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| data_o | output | NBITS | Last captured word, MSB first on the line |
| valid_o | output | 1 | One-cycle strobe that data_o is new |
| err_o | output | 1 | Sticky flag: end of conversion never seen |

## Verification
The bench targets the boundaries of the end-of-conversion window. One case has the converter pull the line low exactly at T_MIN, and another has it pull low at T_MAX, where a design with the wrong priority would report a timeout. A low glitch on the data line before T_MIN is also injected; a design that accepted it would start clocking early and capture a shifted, wrong word. Other cases cover a conversion that never ends, which must give err_o without a valid strobe or any clock edge, and a second start in the middle of a frame, which a careless design would take as a second conversion. Bit patterns with single set bits at either end expose wrong bit order or an off-by-one sample point. Counting clock edges and high-phase cycles exposes a missing or extra edge.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HOLD  = 3'd1,
    S_WAIT  = 3'd2,
    S_SHIFT = 3'd3,
    S_FIN   = 3'd4
  } rd_state_t;
endpackage

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
  parameter int SEL_HOLD = 4,
  parameter int T_MIN    = 20,
  parameter int T_MAX    = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic hold_done,
  output logic min_ok,
  output logic expired
);
  localparam int CW = $clog2(T_MAX + 1) + 1;

  logic [CW-1:0] cnt;

  // Counts cycles since the convert line rose; saturates at T_MAX.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != CW'(T_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hold_done = (cnt == CW'(SEL_HOLD - 1));
  assign min_ok    = (cnt >= CW'(T_MIN));
  assign expired   = (cnt == CW'(T_MAX));
endmodule

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic ph_end
);
  localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PW-1:0] ph;

  // Starts low; each level lasts HALF_CYC cycles while run is high.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (ph == PW'(HALF_CYC - 1)) begin
      ph   <= '0;
      sclk <= ~sclk;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign ph_end = (ph == PW'(HALF_CYC - 1));
endmodule

// File: rtl/sar_bit_capture.sv
module sar_bit_capture #(
  parameter int NBITS      = 18,
  parameter int EXTRA_EDGE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             smp,
  input  logic             fall,
  input  logic             sdo,
  output logic [NBITS-1:0] word,
  output logic             done
);
  localparam int FW = $clog2(NBITS + 2);

  logic [FW-1:0]    fc;
  logic [NBITS-1:0] sr;
  logic             take;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fc <= '0;
    end else if (fall) begin
      fc <= fc + 1'b1;
    end
  end

  // One sample per low phase that follows a falling edge.
  assign take = smp && (fc != '0) && (fc <= FW'(NBITS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr <= '0;
    end else if (take) begin
      sr <= {sr[NBITS-2:0], sdo};
    end
  end

  generate
    if (EXTRA_EDGE != 0) begin : g_tail_edge
      assign done = fall && (fc == FW'(NBITS));
    end else begin : g_no_tail
      assign done = smp && (fc == FW'(NBITS));
    end
  endgenerate

  assign word = sr;
endmodule

// File: rtl/sar_readout.sv
module sar_readout
  import sar_rd_pkg::*;
#(
  parameter int NBITS      = 18,
  parameter int HALF_CYC   = 2,
  parameter int SEL_HOLD   = 4,
  parameter int T_MIN      = 20,
  parameter int T_MAX      = 60,
  parameter int EXTRA_EDGE = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             sdo_i,
  output logic             conv_o,
  output logic             sel_o,
  output logic             sclk_o,
  output logic [NBITS-1:0] data_o,
  output logic             valid_o,
  output logic             err_o
);
  rd_state_t        state;
  logic             timed_out;
  logic             launch;
  logic             hold_done, min_ok, expired;
  logic             sclk, ph_end;
  logic             in_shift, fall, smp, run, done;
  logic [NBITS-1:0] word;

  assign launch   = (state == S_IDLE) && start_i;
  assign in_shift = (state == S_SHIFT);
  assign fall     = in_shift && sclk && ph_end;
  assign smp      = in_shift && !sclk && ph_end;
  assign run      = in_shift && !done;

  sar_conv_timer #(
    .SEL_HOLD(SEL_HOLD), .T_MIN(T_MIN), .T_MAX(T_MAX)
  ) u_timer (
    .clk(clk), .rst(rst), .clr(launch),
    .hold_done(hold_done), .min_ok(min_ok), .expired(expired)
  );

  sar_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
    .clk(clk), .rst(rst), .run(run), .sclk(sclk), .ph_end(ph_end)
  );

  sar_bit_capture #(.NBITS(NBITS), .EXTRA_EDGE(EXTRA_EDGE)) u_cap (
    .clk(clk), .rst(rst), .clr(launch), .smp(smp), .fall(fall),
    .sdo(sdo_i), .word(word), .done(done)
  );

  assign sclk_o = sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      conv_o    <= 1'b0;
      sel_o     <= 1'b1;
      valid_o   <= 1'b0;
      err_o     <= 1'b0;
      timed_out <= 1'b0;
      data_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start_i) begin
            conv_o <= 1'b1;
            sel_o  <= 1'b1;
            err_o  <= 1'b0;
            state  <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (hold_done) begin
            sel_o <= 1'b0;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (min_ok && !sdo_i) begin
            state <= S_SHIFT;
          end else if (expired) begin
            timed_out <= 1'b1;
            state     <= S_FIN;
          end
        end
        S_SHIFT: begin
          if (done) state <= S_FIN;
        end
        S_FIN: begin
          conv_o    <= 1'b0;
          sel_o     <= 1'b1;
          valid_o   <= !timed_out;
          err_o     <= timed_out;
          timed_out <= 1'b0;
          if (!timed_out) data_o <= word;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
  parameter int NBITS      = 18,
  parameter int T_MIN      = 20,
  parameter int EXTRA_EDGE = 1
) (
  input logic clk,
  input logic rst,
  input logic conv_o,
  input logic sel_o,
  input logic sclk_o,
  input logic valid_o,
  input logic err_o
);
  logic [15:0] cyc;
  logic [7:0]  rises;
  logic        sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc    <= '0;
      rises  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (!conv_o) begin
        cyc   <= '0;
        rises <= '0;
      end else begin
        if (cyc != 16'hFFFF) cyc <= cyc + 1'b1;
        if (sclk_o && !sclk_q) rises <= rises + 1'b1;
      end
    end
  end

  p_sel_at_conv_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_o) |-> sel_o);

  p_sel_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (conv_o && cyc >= 16'(T_MIN)) |-> !sel_o);

  p_conv_end_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_o) |-> (valid_o || err_o));

  p_no_early_clk_r4: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> (cyc >= 16'(T_MIN)));

  p_clk_sel_low_r5: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> (!sel_o && conv_o));

  p_edge_count_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (rises == 8'(NBITS + EXTRA_EDGE)));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_err_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && err_o));
endmodule

bind sar_readout sar_readout_chk #(
  .NBITS(NBITS), .T_MIN(T_MIN), .EXTRA_EDGE(EXTRA_EDGE)
) u_chk (
  .clk(clk), .rst(rst), .conv_o(conv_o), .sel_o(sel_o),
  .sclk_o(sclk_o), .valid_o(valid_o), .err_o(err_o)
);

// File: tb/sim_sar_readout.sv
module sim_sar_readout;
  localparam int NB   = 18;
  localparam int HC   = 2;
  localparam int SH   = 4;
  localparam int TMIN = 20;
  localparam int TMAX = 60;
  localparam int XE   = 1;
  localparam int NV   = 6;

  localparam logic [NB-1:0] VW [NV] = '{18'h3FFFF, 18'h00000, 18'h2AAAA,
                                        18'h15555, 18'h20001, 18'h1E0F3};
  localparam int VT [NV] = '{20, 35, 60, 25, 20, 44};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic sdo_r = 1'b1;
  logic conv_o, sel_o, sclk_o, valid_o, err_o;
  logic [NB-1:0] data_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit ended = 0;

  // converter model controls and observations
  logic [NB-1:0] m_word = '0;
  int  m_tconv = 30;
  bit  m_glitch = 0;
  bit  m_never = 0;
  bit  m_active = 0;
  int  m_cnt = 0, m_fall = 0, m_rises = 0, m_hi = 0, m_selhi = 0;
  logic conv_prev = 1'b0, sclk_prev = 1'b0;

  always #5 clk = ~clk;

  sar_readout #(
    .NBITS(NB), .HALF_CYC(HC), .SEL_HOLD(SH),
    .T_MIN(TMIN), .T_MAX(TMAX), .EXTRA_EDGE(XE)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .sdo_i(sdo_r),
    .conv_o(conv_o), .sel_o(sel_o), .sclk_o(sclk_o),
    .data_o(data_o), .valid_o(valid_o), .err_o(err_o)
  );

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !ended) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  // converter behaviour, evaluated between active edges
  always @(negedge clk) begin
    if (conv_o && !conv_prev) begin
      m_active = sel_o;
      m_cnt = 0; m_fall = 0; m_rises = 0; m_hi = 0;
      m_selhi = sel_o ? 1 : 0;
      sdo_r = 1'b1;
    end else if (conv_o && m_active) begin
      m_cnt = m_cnt + 1;
      if (sel_o) m_selhi = m_selhi + 1;
      if (m_glitch && m_cnt >= 6 && m_cnt < 9) sdo_r = 1'b0;
      if (m_glitch && m_cnt == 9) sdo_r = 1'b1;
      if (m_cnt == m_tconv && !m_never) sdo_r = sel_o ? 1'b1 : 1'b0;
      if (sclk_o) m_hi = m_hi + 1;
      if (sclk_o && !sclk_prev) m_rises = m_rises + 1;
      if (sclk_prev && !sclk_o) begin
        m_fall = m_fall + 1;
        sdo_r = (m_fall <= NB) ? m_word[NB - m_fall] : 1'b1;
      end
    end else if (!conv_o) begin
      sdo_r = 1'b1;
      m_active = 0;
    end
    conv_prev = conv_o;
    sclk_prev = sclk_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // runs one frame; got is 1 for valid, 2 for error, 0 for none
  task automatic frame(input logic [NB-1:0] w, input int t, input bit gl,
                       input bit nv, input bit restart, output int got);
    m_word = w; m_tconv = t; m_glitch = gl; m_never = nv;
    got = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 400 && got == 0; i++) begin
      @(negedge clk);
      if (restart && i == 10) start_i = 1'b1;
      if (restart && i == 11) start_i = 1'b0;
      if (valid_o) got = 1;
      else if (err_o) got = 2;
    end
  endtask

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 conv", conv_o, 0);
    chk("R1 sel", sel_o, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 err", err_o, 0);

    for (int v = 0; v < NV; v++) begin
      frame(VW[v], VT[v], 1'b0, 1'b0, 1'b0, got);
      chk("R8 valid strobe", got, 1);
      chk("R6 word MSB first", int'(data_o), int'(VW[v]));
      chk("R7 rising edges", m_rises, NB + XE);
      chk("R6 high phase cycles", m_hi, (NB + XE) * HC);
      chk("R2 select hold", m_selhi, SH);
      chk("R8 conv low at strobe", conv_o, 0);
      chk("R8 sel high at strobe", sel_o, 1);
      @(negedge clk);
      chk("R8 strobe one cycle", valid_o, 0);
      chk("R8 data held", int'(data_o), int'(VW[v]));
    end

    // early low on the data line must be ignored
    frame(18'h2C3A5, 30, 1'b1, 1'b0, 1'b0, got);
    chk("R4 glitch ignored strobe", got, 1);
    chk("R4 glitch ignored word", int'(data_o), int'(18'h2C3A5));

    // start during a frame has no effect
    frame(18'h0F0F0, 28, 1'b0, 1'b0, 1'b1, got);
    chk("R10 frame word", int'(data_o), int'(18'h0F0F0));
    begin
      int hi = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (conv_o) hi = hi + 1;
      end
      chk("R10 no second conversion", hi, 0);
    end

    // converter never finishes
    frame(18'h12345, 0, 1'b0, 1'b1, 1'b0, got);
    chk("R9 timeout flagged", got, 2);
    chk("R9 no clock edges", m_rises, 0);
    chk("R9 conv low", conv_o, 0);
    chk("R9 word kept", int'(data_o), int'(18'h0F0F0));
    repeat (5) @(negedge clk);
    chk("R9 err sticky", err_o, 1);
    chk("R9 no strobe", valid_o, 0);

    // recovery after timeout
    frame(18'h3A5C1, 40, 1'b0, 1'b0, 1'b0, got);
    chk("R9 recovery strobe", got, 1);
    chk("R9 err cleared", err_o, 0);
    chk("R3 recovery word", int'(data_o), int'(18'h3A5C1));

    summary();
  end
endmodule